// File: doc/BRIEF.md
# Page-Aware Instruction Prefetch Buffer

This block keeps a short run of instruction bytes close to the fetch logic. A fetch request gives a linear address, the segment offset and limit, and a byte count of one to four. When the requested bytes already sit in the buffer, they come back one cycle later with no memory traffic. Otherwise the block refills the whole line from a linear-memory read port. The refill is a series of 4-byte reads over a valid/ready request channel with a response strobe. The block then returns the requested bytes from the refreshed line.

The window is placed so that it never reaches past the end of a page while paging is on. If the segment limit is too close for a full line, or if the requested bytes would run beyond the clamped window, the block skips the line. In that case it issues one direct read of exactly the requested bytes. Data writes elsewhere in the pipeline are presented on a snoop port, and writes that land wholly inside the live window patch the buffered copy. An invalidate strobe, used for example on a context switch, drops the line.

Top module: `ifetch_pbuf`

## Requirements
- R1: Out of reset, `done`, `error`, `busy` and `mem_req_valid` are low and the line is empty, so the first fetch always goes to memory.
- R2: A line refill is allowed only when `req_offset + LINE_BYTES - 1 <= req_limit`. Otherwise the block makes a single direct read at the fetch address with `mem_rd_bytes` equal to the request size, and it returns the response with the bytes above that size forced to zero.
- R3: A refill makes LINE_BYTES/4 reads of 4 bytes at window start + 0, 4, 8, ... in that order. The answer is taken from line index (fetch address − window start). Byte k of the answer is placed in `fetch_data[8k+7:8k]` (little-endian), and unused upper bytes are zero.
- R4: With `paging_en` high and a fetch address page offset above PAGE_BYTES − LINE_BYTES, the window start becomes the page base plus PAGE_BYTES − LINE_BYTES. In every other case the window starts at the fetch address itself, even if it then crosses a page.
- R5: After placement, if (fetch address − window start + size) >= LINE_BYTES, the line is marked empty and a direct read is made. Exact equality also counts as a bypass.
- R6: A fetch whose bytes lie wholly inside a valid window sets `done` on the next clock edge and issues no memory read.
- R7: A refill read that returns `mem_rsp_err` ends the fetch with `done` and `error` both high, and it leaves the line empty.
- R8: A snoop write whose bytes lie wholly inside a valid window replaces those buffered bytes, with snoop byte k taken from `snoop_data[8k+7:8k]`. A snoop write that reaches outside the window, or one that arrives while no line is valid, changes nothing.
- R9: `inval` empties the line. An invalidate or any snoop write seen during a refill leaves the line empty once that refill completes, but the fetch is still answered.
- R10: While `mem_req_valid` is high and `mem_req_ready` low, the request and its address stay unchanged. At most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request, taken when `busy` is low |
| req_lin_addr | input | AW | Linear address of the first requested byte |
| req_offset | input | AW | Segment offset of that byte |
| req_limit | input | AW | Segment limit |
| req_size | input | 3 | Bytes requested, 1 to 4 |
| paging_en | input | 1 | Paging enabled |
| snoop_valid | input | 1 | A data write is being performed |
| snoop_addr | input | AW | Linear address of the write |
| snoop_data | input | 32 | Write data, little-endian |
| snoop_bytes | input | 3 | Bytes written, 1 to 4 |
| inval | input | 1 | Drop the buffered line |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read address |
| mem_rd_bytes | output | 3 | Bytes to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data, little-endian |
| mem_rsp_err | input | 1 | Read failed |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion carried a read failure |
| fetch_data | output | 32 | Fetched bytes, valid with `done` |

## Verification
Wrong internal state shows up at the ports in a few ways. A stale valid flag appears as a fetch that completes in one cycle with no memory read. A lost valid flag appears as a refill burst where a hit was expected. A misplaced window start appears as a wrong first refill address and wrong returned bytes on the same fetch. Snoop mistakes stay hidden until the next fetch that hits the patched bytes, so every snoop case is followed at once by such a fetch. Invalidate and error cases are each followed by a repeat fetch of the same address, whose read count tells whether the line survived.

// File: rtl/ifpb_pkg.sv
// Package: shared state encoding and byte-mask helper for the prefetch buffer.
// Assumes byte counts of 1 to 4 on 32-bit data paths.
package ifpb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL_REQ,
        S_FILL_WAIT,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_SERVE
    } pb_state_t;

    // Mask keeping the lowest n bytes of a 32-bit little-endian word.
    function automatic logic [31:0] size_mask(input logic [2:0] n);
        if (n >= 3'd4) return '1;
        return (32'd1 << (32'(n) << 3)) - 32'd1;
    endfunction

endpackage

// File: rtl/ifpb_window.sv
// Module: window placement and hit/bypass decisions for one fetch request.
// Purely combinational apart from its checks. Assumes PAGE_BYTES and
// LINE_BYTES are powers of two with LINE_BYTES < PAGE_BYTES.
module ifpb_window #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] limit,
    input  logic [2:0]    size,
    input  logic          paging_en,
    input  logic          buf_valid,
    input  logic [AW-1:0] buf_base,
    output logic [AW-1:0] win_start,
    output logic          pf_ok,
    output logic          bypass,
    output logic          hit
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam logic [PW-1:0] LAST_START = PW'(PAGE_BYTES - LINE_BYTES);

    logic          clamp;
    logic [AW-1:0] span;

    // Place the window, then decide prefetch eligibility, bypass and hit.
    always_comb begin
        pf_ok     = ({1'b0, offset} + (AW+1)'(LINE_BYTES - 1)) <= {1'b0, limit};
        clamp     = paging_en && (fetch_addr[PW-1:0] > LAST_START);
        win_start = clamp ? {fetch_addr[AW-1:PW], LAST_START} : fetch_addr;
        span      = (fetch_addr - win_start) + AW'(size);
        bypass    = span >= AW'(LINE_BYTES);
        hit       = buf_valid && (fetch_addr >= buf_base) &&
                    (({1'b0, fetch_addr} + (AW+1)'(size)) <=
                     ({1'b0, buf_base} + (AW+1)'(LINE_BYTES)));
    end

    // R4: with paging on, a placed window always ends inside its page.
    a_r4_window_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && paging_en) |-> (win_start[PW-1:0] <= LAST_START));

endmodule

// File: rtl/ifpb_line.sv
// Module: byte storage for one prefetch line with a word-fill port, a
// byte-granular snoop patch port and a little-endian read port.
// Assumes fill and snoop writes never target the line in the same cycle
// (the controller guarantees this); storage is not reset by design.
module ifpb_line #(
    parameter int LINE_BYTES = 16
) (
    input  logic                            clk,
    input  logic                            fill_we,
    input  logic [$clog2(LINE_BYTES/4)-1:0] fill_idx,
    input  logic [31:0]                     fill_word,
    input  logic                            snp_we,
    input  logic [$clog2(LINE_BYTES)-1:0]   snp_idx,
    input  logic [2:0]                      snp_bytes,
    input  logic [31:0]                     snp_data,
    input  logic [$clog2(LINE_BYTES)-1:0]   rd_idx,
    input  logic [2:0]                      rd_size,
    output logic [31:0]                     rd_data
);
    localparam int LW = $clog2(LINE_BYTES);

    logic [7:0] bytes_q [LINE_BYTES];

    // Write one fill word, or patch snooped bytes.
    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (fill_we)
                bytes_q[{fill_idx, 2'(k)}] <= fill_word[8*k +: 8];
            else if (snp_we && (3'(k) < snp_bytes))
                bytes_q[snp_idx + LW'(k)] <= snp_data[8*k +: 8];
        end
    end

    // Assemble up to four bytes little-endian, zeroing unused lanes.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            rd_data[8*k +: 8] = (3'(k) < rd_size) ? bytes_q[rd_idx + LW'(k)] : 8'h00;
        end
    end

endmodule

// File: rtl/ifetch_pbuf.sv
// Module: instruction prefetch buffer controller. Serves fetches from one
// line, refills it with sequential 4-byte reads, falls back to direct reads
// near limits and page ends, and patches the line from snooped writes.
// Assumes req_size and snoop_bytes are 1..4 and one read in flight.
module ifetch_pbuf
    import ifpb_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_lin_addr,
    input  logic [AW-1:0] req_offset,
    input  logic [AW-1:0] req_limit,
    input  logic [2:0]    req_size,
    input  logic          paging_en,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic [31:0]   snoop_data,
    input  logic [2:0]    snoop_bytes,
    input  logic          inval,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic [2:0]    mem_rd_bytes,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    input  logic          mem_rsp_err,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [31:0]   fetch_data
);
    localparam int LW     = $clog2(LINE_BYTES);
    localparam int NWORDS = LINE_BYTES / 4;
    localparam int CW     = $clog2(NWORDS);
    localparam logic [CW-1:0] LAST_WORD = CW'(NWORDS - 1);

    pb_state_t     state;
    logic          buf_valid;
    logic [AW-1:0] buf_base;
    logic [CW-1:0] wcnt;
    logic          taint;
    logic [AW-1:0] addr_q;
    logic [2:0]    size_q;

    logic          accept;
    logic [AW-1:0] win_start;
    logic          pf_ok, bypass, hit;
    logic          snp_inside, snp_we, fill_we, fill_last;
    logic [LW-1:0] rd_idx;
    logic [2:0]    rd_size;
    logic [31:0]   line_rd;

    assign accept = req_valid && (state == S_IDLE);
    assign busy   = (state != S_IDLE);

    ifpb_window #(.AW(AW), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_en     (accept),
        .fetch_addr (req_lin_addr),
        .offset     (req_offset),
        .limit      (req_limit),
        .size       (req_size),
        .paging_en  (paging_en),
        .buf_valid  (buf_valid),
        .buf_base   (buf_base),
        .win_start  (win_start),
        .pf_ok      (pf_ok),
        .bypass     (bypass),
        .hit        (hit)
    );

    // Snoop qualification and line port steering.
    always_comb begin
        snp_inside = (snoop_addr >= buf_base) &&
                     (({1'b0, snoop_addr} + (AW+1)'(snoop_bytes)) <=
                      ({1'b0, buf_base} + (AW+1)'(LINE_BYTES)));
        snp_we     = snoop_valid && buf_valid && snp_inside;
        fill_we    = (state == S_FILL_WAIT) && mem_rsp_valid && !mem_rsp_err;
        fill_last  = fill_we && (wcnt == LAST_WORD);
        if (state == S_SERVE) begin
            rd_idx  = LW'(addr_q - buf_base);
            rd_size = size_q;
        end else begin
            rd_idx  = LW'(req_lin_addr - buf_base);
            rd_size = req_size;
        end
    end

    ifpb_line #(.LINE_BYTES(LINE_BYTES)) u_line (
        .clk       (clk),
        .fill_we   (fill_we),
        .fill_idx  (wcnt),
        .fill_word (mem_rsp_data),
        .snp_we    (snp_we),
        .snp_idx   (LW'(snoop_addr - buf_base)),
        .snp_bytes (snoop_bytes),
        .snp_data  (snoop_data),
        .rd_idx    (rd_idx),
        .rd_size   (rd_size),
        .rd_data   (line_rd)
    );

    // Memory request channel driven from the current state.
    always_comb begin
        mem_req_valid = (state == S_FILL_REQ) || (state == S_DIR_REQ);
        if (state == S_FILL_REQ) begin
            mem_req_addr = buf_base + AW'({wcnt, 2'b00});
            mem_rd_bytes = 3'd4;
        end else begin
            mem_req_addr = addr_q;
            mem_rd_bytes = size_q;
        end
    end

    // Fetch sequencing, line validity and completion outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            buf_valid  <= 1'b0;
            buf_base   <= '0;
            wcnt       <= '0;
            taint      <= 1'b0;
            addr_q     <= '0;
            size_q     <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
            fetch_data <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (((state == S_FILL_REQ) || (state == S_FILL_WAIT)) && (inval || snoop_valid))
                taint <= 1'b1;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_lin_addr;
                        size_q <= req_size;
                        if (hit) begin
                            done       <= 1'b1;
                            fetch_data <= line_rd;
                        end else if (pf_ok && !bypass) begin
                            buf_valid <= 1'b0;
                            buf_base  <= win_start;
                            wcnt      <= '0;
                            taint     <= 1'b0;
                            state     <= S_FILL_REQ;
                        end else begin
                            if (pf_ok) buf_valid <= 1'b0;
                            state <= S_DIR_REQ;
                        end
                    end
                end
                S_FILL_REQ: if (mem_req_ready) state <= S_FILL_WAIT;
                S_FILL_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            done  <= 1'b1;
                            error <= 1'b1;
                            state <= S_IDLE;
                        end else if (fill_last) begin
                            buf_valid <= !(taint || inval || snoop_valid);
                            state     <= S_SERVE;
                        end else begin
                            wcnt  <= wcnt + 1'b1;
                            state <= S_FILL_REQ;
                        end
                    end
                end
                S_SERVE: begin
                    done       <= 1'b1;
                    fetch_data <= line_rd;
                    state      <= S_IDLE;
                end
                S_DIR_REQ: if (mem_req_ready) state <= S_DIR_WAIT;
                S_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        done       <= 1'b1;
                        error      <= mem_rsp_err;
                        fetch_data <= mem_rsp_data & size_mask(size_q);
                        state      <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
            if (inval) buf_valid <= 1'b0;
        end
    end

    // R6: a hit completes on the next edge without touching memory.
    a_r6_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (done && !mem_req_valid));

    // R5: a bypassed fetch empties the line and goes to a direct read.
    a_r5_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit && pf_ok && bypass) |=> (!buf_valid && mem_req_valid && (mem_rd_bytes == $past(req_size))));

    // R7: a failed refill read reports an error and leaves the line empty.
    a_r7_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_FILL_WAIT) && mem_rsp_valid && mem_rsp_err) |=> (done && error && !buf_valid));

    // R9: the invalidate strobe always empties the line.
    a_r9_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !buf_valid);

    // R10: a stalled request holds its address.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/test_ifetch_pbuf.sv
`timescale 1ns/1ps
module test_ifetch_pbuf;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_lin_addr = '0, req_offset = '0, req_limit = '0;
    logic [2:0]    req_size = 3'd1;
    logic          paging_en = 1'b0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic [31:0]   snoop_data = '0;
    logic [2:0]    snoop_bytes = 3'd1;
    logic          inval = 1'b0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic [2:0]    mem_rd_bytes;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;
    logic          busy, done, error;
    logic [31:0]   fetch_data;

    int n_checks = 0;
    int n_fail = 0;
    int n_reads = 0;
    logic          err_inject = 1'b0;
    logic [AW-1:0] rd_addr_log [8];
    logic [2:0]    rd_size_log [8];
    logic [31:0]   got_data;
    logic          got_err;
    int            got_cycles;

    always #4 clk = ~clk;

    ifetch_pbuf i_ifetch_pbuf (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_lin_addr(req_lin_addr), .req_offset(req_offset),
        .req_limit(req_limit), .req_size(req_size), .paging_en(paging_en),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_data(snoop_data),
        .snoop_bytes(snoop_bytes), .inval(inval),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rd_bytes(mem_rd_bytes),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .busy(busy), .done(done), .error(error), .fetch_data(fetch_data)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a, input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (k < n) w[8*k +: 8] = mbyte(a + 32'(k));
        return w;
    endfunction

    // Memory model: one-cycle response to every accepted read.
    initial begin
        forever begin
            @(posedge clk);
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mword(mem_req_addr, 4);
                mem_rsp_err   <= err_inject;
                if (n_reads < 8) begin
                    rd_addr_log[n_reads] = mem_req_addr;
                    rd_size_log[n_reads] = mem_rd_bytes;
                end
                n_reads = n_reads + 1;
            end
        end
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Issue one fetch and wait for completion.
    task automatic fetch(input logic [31:0] a, input logic [31:0] off, input logic [31:0] lim,
                         input logic [2:0] sz, input logic pg);
        @(negedge clk);
        n_reads = 0;
        req_valid = 1'b1; req_lin_addr = a; req_offset = off; req_limit = lim;
        req_size = sz; paging_en = pg;
        @(negedge clk);
        req_valid = 1'b0;
        got_cycles = 1;
        while (!done && got_cycles < 100) begin
            @(negedge clk);
            got_cycles++;
        end
        if (!done) check(1'b0, "timeout", 32'(got_cycles), 32'd100);
        got_data = fetch_data;
        got_err = error;
    endtask

    task automatic snoop(input logic [31:0] a, input logic [31:0] d, input logic [2:0] n);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a; snoop_data = d; snoop_bytes = n;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(!done && !error && !busy && !mem_req_valid, "R1 idle outputs after reset",
              {28'd0, done, error, busy, mem_req_valid}, 32'd0);
    endtask

    task automatic t_fill_and_hit();
        fetch(32'h1000_0100, 32'h100, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 4, "R1 empty line misses / R3 refill count", 32'(n_reads), 32'd4);
        check(rd_addr_log[0] == 32'h1000_0100 && rd_addr_log[3] == 32'h1000_010C && rd_size_log[1] == 3'd4,
              "R3 refill addresses", rd_addr_log[3], 32'h1000_010C);
        check(got_data == mword(32'h1000_0100, 4), "R3 data", got_data, mword(32'h1000_0100, 4));
        fetch(32'h1000_0105, 32'h105, 32'hFFFF, 3'd3, 1'b1);
        check(n_reads == 0 && got_cycles == 1, "R6 hit latency", 32'(got_cycles), 32'd1);
        check(got_data == mword(32'h1000_0105, 3), "R6 hit data upper zero", got_data, mword(32'h1000_0105, 3));
        fetch(32'h1000_010C, 32'h10C, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 0 && got_data == mword(32'h1000_010C, 4), "R6 hit at window end", got_data, mword(32'h1000_010C, 4));
        fetch(32'h1000_010D, 32'h10D, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 4 && rd_addr_log[0] == 32'h1000_010D, "R6 spill past window misses", rd_addr_log[0], 32'h1000_010D);
        check(got_data == mword(32'h1000_010D, 4), "R3 unaligned window data", got_data, mword(32'h1000_010D, 4));
    endtask

    task automatic t_clamp();
        fetch(32'h2000_0FF4, 32'hFF4, 32'hFFFF, 3'd2, 1'b1);
        check(n_reads == 4 && rd_addr_log[0] == 32'h2000_0FF0, "R4 clamped window start", rd_addr_log[0], 32'h2000_0FF0);
        check(got_data == mword(32'h2000_0FF4, 2), "R4 clamped data", got_data, mword(32'h2000_0FF4, 2));
        fetch(32'h2000_0FF0, 32'hFF0, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 0 && got_data == mword(32'h2000_0FF0, 4), "R4 hit below fetch address", got_data, mword(32'h2000_0FF0, 4));
        fetch(32'h3000_0FF4, 32'hFF4, 32'hFFFF, 3'd2, 1'b0);
        check(n_reads == 4 && rd_addr_log[0] == 32'h3000_0FF4, "R4 no clamp without paging", rd_addr_log[0], 32'h3000_0FF4);
    endtask

    task automatic t_bypass();
        fetch(32'h4000_0FFD, 32'hFFD, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 1 && rd_addr_log[0] == 32'h4000_0FFD && rd_size_log[0] == 3'd4,
              "R5 direct read", rd_addr_log[0], 32'h4000_0FFD);
        check(got_data == mword(32'h4000_0FFD, 4), "R5 direct data", got_data, mword(32'h4000_0FFD, 4));
        fetch(32'h3000_0FF4, 32'hFF4, 32'hFFFF, 3'd1, 1'b0);
        check(n_reads == 4, "R5 bypass emptied line", 32'(n_reads), 32'd4);
        fetch(32'h4000_0FFC, 32'hFFC, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 1 && rd_size_log[0] == 3'd4, "R5 exact fit bypasses", 32'(n_reads), 32'd1);
    endtask

    task automatic t_limit();
        fetch(32'h6000_0050, 32'h50, 32'h5E, 3'd2, 1'b1);
        check(n_reads == 1 && rd_size_log[0] == 3'd2 && rd_addr_log[0] == 32'h6000_0050,
              "R2 limit forces direct read", 32'(rd_size_log[0]), 32'd2);
        check(got_data == mword(32'h6000_0050, 2), "R2 direct data masked", got_data, mword(32'h6000_0050, 2));
        fetch(32'h6000_0050, 32'h50, 32'h5F, 3'd2, 1'b1);
        check(n_reads == 4, "R2 limit at boundary allows refill", 32'(n_reads), 32'd4);
    endtask

    task automatic t_snoop();
        fetch(32'h5000_0200, 32'h200, 32'hFFFF, 3'd1, 1'b1);
        snoop(32'h5000_0206, 32'h0000_BEEF, 3'd2);
        fetch(32'h5000_0204, 32'h204, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 0 && got_data == {16'hBEEF, mbyte(32'h5000_0205), mbyte(32'h5000_0204)},
              "R8 snoop patches line", got_data, {16'hBEEF, mbyte(32'h5000_0205), mbyte(32'h5000_0204)});
        snoop(32'h5000_020E, 32'h1122_3344, 3'd4);
        fetch(32'h5000_020C, 32'h20C, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 0 && got_data == mword(32'h5000_020C, 4), "R8 straddling snoop ignored",
              got_data, mword(32'h5000_020C, 4));
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        snoop(32'h5000_0204, 32'hDEAD_BEEF, 3'd4);
        fetch(32'h5000_0204, 32'h204, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 4, "R9 invalidate empties line", 32'(n_reads), 32'd4);
        check(got_data == mword(32'h5000_0204, 4), "R8 snoop on empty line ignored", got_data, mword(32'h5000_0204, 4));
    endtask

    task automatic t_taint();
        @(negedge clk);
        n_reads = 0;
        req_valid = 1'b1; req_lin_addr = 32'h5000_0300; req_offset = 32'h300;
        req_limit = 32'hFFFF; req_size = 3'd4; paging_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        snoop_valid = 1'b1; snoop_addr = 32'h9000_0000; snoop_bytes = 3'd4;
        @(negedge clk);
        snoop_valid = 1'b0;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(done && fetch_data == mword(32'h5000_0300, 4), "R9 tainted fill still answers",
              fetch_data, mword(32'h5000_0300, 4));
        fetch(32'h5000_0300, 32'h300, 32'hFFFF, 3'd4, 1'b1);
        check(n_reads == 4, "R9 snoop during fill leaves line empty", 32'(n_reads), 32'd4);
    endtask

    task automatic t_error();
        err_inject = 1'b1;
        fetch(32'h7000_0000, 32'h0, 32'hFFFF, 3'd4, 1'b1);
        err_inject = 1'b0;
        check(got_err && n_reads == 1, "R7 refill error reported", {31'd0, got_err}, 32'd1);
        fetch(32'h7000_0000, 32'h0, 32'hFFFF, 3'd4, 1'b1);
        check(!got_err && n_reads == 4, "R7 line empty after error", 32'(n_reads), 32'd4);
    endtask

    task automatic t_stall();
        @(negedge clk);
        n_reads = 0;
        mem_req_ready = 1'b0;
        req_valid = 1'b1; req_lin_addr = 32'h7100_0000; req_offset = 32'h0;
        req_limit = 32'hFFFF; req_size = 3'd4; paging_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(mem_req_valid && mem_req_addr == 32'h7100_0000, "R10 request held under stall",
                  mem_req_addr, 32'h7100_0000);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(done && n_reads == 4 && fetch_data == mword(32'h7100_0000, 4), "R10 stalled refill completes",
              fetch_data, mword(32'h7100_0000, 4));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_hit();
        t_clamp();
        t_bypass();
        t_limit();
        t_snoop();
        t_taint();
        t_error();
        t_stall();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule